// File: doc/BRIEF.md
# Left-Right Disparity Consistency Checker

This block validates a dense disparity map by comparing matches computed in opposite directions. A stereo pipeline delivers two disparity streams for the same scanline. The right-referenced stream is written into a line store. The left-referenced stream is then checked pixel by pixel against it. For a left pixel at column x with disparity d, the block reads the right-referenced disparity stored at column x−d. It keeps d only when the two values agree within a small tolerance.

Pixels that fail are not dropped. Their disparity is replaced by a reserved flag code, so downstream display or filtering logic can tell them apart while the output keeps one word per input pixel. The line store has two banks. While one completed right-referenced line is being checked against its left partner, the next right-referenced line can already be filling the other bank. A running count of flagged pixels in the current frame is also provided.

Top module: `lr_disp_check`

## Requirements
- R1: Every left pixel accepted with `l_valid` high gives exactly one output word with `o_valid` high on the following clock cycle, in input order; `o_valid` is low in every other cycle.
- R2: `o_sol` and `o_sof` are high together with the output word of the left pixel that carried `l_sol` or `l_sof` respectively, and low otherwise.
- R3: With column x (0 at the `l_sol` pixel, counting accepted pixels), left disparity d and stored right disparity r at column x−d, the output equals d when |d − r| ≤ TOL (default 1).
- R4: When |d − r| > TOL, the output is the flag code INV, which by default is 255 (all ones of the DW-bit word).
- R5: When x < d, the reverse position lies left of the line start and the output is INV, whatever the store holds.
- R6: When d equals INV, or the stored r equals INV, the output is INV.
- R7: A right-referenced line of W pixels, started by `r_sol`, fills one bank. The k-th left line is checked against the k-th right line. The next right line may be written while the previous left line is being checked. A bank is freed after the W-th pixel of its left line.
- R8: `o_bad_cnt` changes only with an output word. It equals the number of INV words output since the last word with `o_sof`, counting that word, and saturates at its maximum.
- R9: After reset, `o_valid`, `o_sol`, `o_sof` and `o_bad_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| r_valid | input | 1 | Right-referenced disparity word present |
| r_sol | input | 1 | First pixel of a right-referenced line |
| r_data | input | DW | Right-referenced disparity |
| l_valid | input | 1 | Left-referenced disparity word present |
| l_sol | input | 1 | First pixel of a left-referenced line |
| l_sof | input | 1 | First pixel of a frame |
| l_data | input | DW | Left-referenced disparity |
| o_valid | output | 1 | Checked word present |
| o_sol | output | 1 | Checked word starts a line |
| o_sof | output | 1 | Checked word starts a frame |
| o_data | output | DW | Accepted disparity or INV |
| o_bad_cnt | output | CW | INV words output in the current frame |

## Verification
The checks assume a well-ordered feed. Every line on both streams is exactly W pixels long and starts with its start-of-line marker. A left line never begins before its right partner has fully landed in a bank. A right line never writes into a bank whose left line is still unchecked. Two assertions state the last two conditions at the bank flags. The stimulus sends complete lines with idle gaps. It starts each right line before the previous left line but never more than one line ahead, so at most two lines are outstanding at any time.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

   typedef struct packed {
      logic sol;
      logic sof;
   } lrc_mark_t;

   function automatic int unsigned lrc_absdiff(input int unsigned a, input int unsigned b);
      return (a > b) ? (a - b) : (b - a);
   endfunction

endpackage

// File: rtl/lrc_col.sv
// Column tracker: position of the current beat within a line.
module lrc_col #(
   parameter int W  = 640,
   parameter int AW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          first,
   output logic [AW-1:0] pos,
   output logic          last
);
   logic [AW-1:0] cnt_q;

   assign pos  = first ? '0 : cnt_q;
   assign last = (pos == AW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (step)
         cnt_q <= last ? '0 : pos + AW'(1);
   end
endmodule

// File: rtl/lrc_line_store.sv
// Two-bank store for right-referenced lines with fill/consume ownership flags.
module lrc_line_store #(
   parameter int W  = 640,
   parameter int DW = 8,
   parameter int AW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_first,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic          rd_first,
   input  logic [AW-1:0] rd_addr,
   output logic [AW-1:0] rd_pos,
   output logic [DW-1:0] rd_data,
   output logic          rd_ready,
   output logic          wr_busy
);
   localparam int NB = 2;

   logic [AW-1:0] wr_pos;
   logic          wr_last;
   logic          rd_last;
   logic          wbank_q;
   logic          rbank_q;
   logic [NB-1:0] full_q;
   logic [DW-1:0] bank_q [NB];

   lrc_col #(.W(W), .AW(AW)) u_wcol (
      .clk(clk), .rst_n(rst_n), .step(wr_en), .first(wr_first),
      .pos(wr_pos), .last(wr_last)
   );

   lrc_col #(.W(W), .AW(AW)) u_rcol (
      .clk(clk), .rst_n(rst_n), .step(rd_en), .first(rd_first),
      .pos(rd_pos), .last(rd_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbank_q <= 1'b0;
         rbank_q <= 1'b0;
         full_q  <= '0;
      end else begin
         if (wr_en && wr_last) begin
            full_q[wbank_q] <= 1'b1;
            wbank_q         <= ~wbank_q;
         end
         if (rd_en && rd_last) begin
            full_q[rbank_q] <= 1'b0;
            rbank_q         <= ~rbank_q;
         end
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [DW-1:0] mem [W];
      always_ff @(posedge clk) begin
         if (wr_en && (wbank_q == 1'(b)))
            mem[wr_pos] <= wr_data;
      end
      assign bank_q[b] = mem[rd_addr];
   end

   assign rd_data  = bank_q[rbank_q];
   assign rd_ready = full_q[rbank_q];
   assign wr_busy  = full_q[wbank_q];
endmodule

// File: rtl/lrc_judge.sv
// Accept/reject decision for one forward/reverse disparity pair.
module lrc_judge
   import lrc_pkg::*;
#(
   parameter int          DW  = 8,
   parameter int unsigned TOL = 1,
   parameter int unsigned INV = 255
) (
   input  logic [DW-1:0] fwd,
   input  logic [DW-1:0] rev,
   input  logic          under,
   output logic          ok
);
   logic flagged;
   logic close;

   assign flagged = (fwd == DW'(INV)) || (rev == DW'(INV)) || under;

   if (TOL == 0) begin : g_exact
      assign close = (fwd == rev);
   end else begin : g_tol
      assign close = lrc_absdiff(int'(unsigned'(fwd)), int'(unsigned'(rev))) <= TOL;
   end

   assign ok = !flagged && close;
endmodule

// File: rtl/lrc_count.sv
// Per-frame saturating counter of flagged output words.
module lrc_count #(
   parameter int CW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit,
   input  logic          restart,
   input  logic          bad,
   output logic [CW-1:0] cnt
);
   logic [CW-1:0] base;
   logic [CW-1:0] nxt;

   assign base = restart ? '0 : cnt;
   assign nxt  = (bad && !(&base)) ? base + CW'(1) : base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (hit)
         cnt <= nxt;
   end
endmodule

// File: rtl/lr_disp_check.sv
module lr_disp_check
   import lrc_pkg::*;
#(
   parameter int          W   = 640,
   parameter int          DW  = 8,
   parameter int unsigned TOL = 1,
   parameter int unsigned INV = (1 << DW) - 1,
   parameter int          CW  = 20,
   parameter int          AW  = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          r_valid,
   input  logic          r_sol,
   input  logic [DW-1:0] r_data,
   input  logic          l_valid,
   input  logic          l_sol,
   input  logic          l_sof,
   input  logic [DW-1:0] l_data,
   output logic          o_valid,
   output logic          o_sol,
   output logic          o_sof,
   output logic [DW-1:0] o_data,
   output logic [CW-1:0] o_bad_cnt
);
   localparam int XW = ((AW > DW) ? AW : DW) + 1;

   if (W < 2) begin : g_err_w
      $error("lr_disp_check: W must be at least 2");
   end
   if (DW < 2 || DW > 16) begin : g_err_dw
      $error("lr_disp_check: DW out of range");
   end
   if (INV >= (1 << DW)) begin : g_err_inv
      $error("lr_disp_check: INV does not fit in DW bits");
   end
   if (TOL >= INV) begin : g_err_tol
      $error("lr_disp_check: TOL must be below INV");
   end
   if (CW < 1) begin : g_err_cw
      $error("lr_disp_check: CW must be positive");
   end

   logic [AW-1:0] x_pos;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rev;
   logic          rd_bank_ready;
   logic          wr_bank_busy;
   logic [XW-1:0] x_ext;
   logic [XW-1:0] d_ext;
   logic [XW-1:0] off_ext;
   logic          under;
   logic          ok;
   lrc_mark_t     mark_q;
   logic          valid_q;
   logic [DW-1:0] data_q;

   assign x_ext   = XW'(x_pos);
   assign d_ext   = XW'(l_data);
   assign under   = (x_ext < d_ext);
   assign off_ext = x_ext - d_ext;
   assign rd_addr = under ? '0 : off_ext[AW-1:0];

   lrc_line_store #(.W(W), .DW(DW), .AW(AW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(r_valid), .wr_first(r_sol), .wr_data(r_data),
      .rd_en(l_valid), .rd_first(l_sol), .rd_addr(rd_addr),
      .rd_pos(x_pos), .rd_data(rev),
      .rd_ready(rd_bank_ready), .wr_busy(wr_bank_busy)
   );

   lrc_judge #(.DW(DW), .TOL(TOL), .INV(INV)) u_judge (
      .fwd(l_data), .rev(rev), .under(under), .ok(ok)
   );

   lrc_count #(.CW(CW)) u_count (
      .clk(clk), .rst_n(rst_n), .hit(l_valid), .restart(l_sof), .bad(!ok),
      .cnt(o_bad_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
         mark_q  <= '0;
      end else begin
         valid_q    <= l_valid;
         mark_q.sol <= l_valid && l_sol;
         mark_q.sof <= l_valid && l_sof;
         if (l_valid)
            data_q <= ok ? l_data : DW'(INV);
      end
   end

   assign o_valid = valid_q;
   assign o_data  = data_q;
   assign o_sol   = mark_q.sol;
   assign o_sof   = mark_q.sof;
endmodule

// File: rtl/lrc_check_sva.sv
module lrc_check_sva #(
   parameter int          DW  = 8,
   parameter int unsigned INV = 255,
   parameter int          CW  = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          r_valid,
   input logic          l_valid,
   input logic          l_sol,
   input logic          l_sof,
   input logic [DW-1:0] l_data,
   input logic          o_valid,
   input logic          o_sol,
   input logic          o_sof,
   input logic [DW-1:0] o_data,
   input logic [CW-1:0] o_bad_cnt,
   input logic          rd_bank_ready,
   input logic          wr_bank_busy
);
   p_out_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      l_valid |=> o_valid);
   p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !l_valid |=> !o_valid);
   p_sol_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (l_valid && l_sol) |=> o_sol);
   p_sof_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (l_valid && l_sof) |=> o_sof);
   p_pass_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_data != DW'(INV)) |-> (o_data == $past(l_data)));
   p_line_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (l_valid && l_sol && l_data != '0) |=> (o_data == DW'(INV)));
   p_flag_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (l_valid && l_data == DW'(INV)) |=> (o_data == DW'(INV)));
   p_left_has_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      l_valid |-> rd_bank_ready);
   p_right_free_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid |-> !wr_bank_busy);
   p_frame_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_sof) |-> (o_bad_cnt <= CW'(1)));
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !o_valid |-> $stable(o_bad_cnt));
   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_sof && !(&$past(o_bad_cnt))) |->
      (o_bad_cnt == $past(o_bad_cnt) + CW'(o_data == DW'(INV))));
endmodule

bind lr_disp_check lrc_check_sva #(.DW(DW), .INV(INV), .CW(CW)) u_sva (
   .clk(clk), .rst_n(rst_n), .r_valid(r_valid),
   .l_valid(l_valid), .l_sol(l_sol), .l_sof(l_sof), .l_data(l_data),
   .o_valid(o_valid), .o_sol(o_sol), .o_sof(o_sof), .o_data(o_data),
   .o_bad_cnt(o_bad_cnt), .rd_bank_ready(rd_bank_ready),
   .wr_bank_busy(wr_bank_busy)
);

// File: tb/sim_lr_disp_check.sv
`timescale 1ns/1ps
module sim_lr_disp_check;
   localparam int W   = 16;
   localparam int DW  = 8;
   localparam int CW  = 12;
   localparam int INV = 255;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          r_valid = 1'b0, r_sol = 1'b0;
   logic [DW-1:0] r_data = '0;
   logic          l_valid = 1'b0, l_sol = 1'b0, l_sof = 1'b0;
   logic [DW-1:0] l_data = '0;
   logic          o_valid, o_sol, o_sof;
   logic [DW-1:0] o_data;
   logic [CW-1:0] o_bad_cnt;

   always #2 clk = ~clk;

   lr_disp_check #(.W(W), .DW(DW), .TOL(1), .INV(INV), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .r_valid(r_valid), .r_sol(r_sol), .r_data(r_data),
      .l_valid(l_valid), .l_sol(l_sol), .l_sof(l_sof), .l_data(l_data),
      .o_valid(o_valid), .o_sol(o_sol), .o_sof(o_sof), .o_data(o_data),
      .o_bad_cnt(o_bad_cnt)
   );

   typedef struct {
      int    data;
      bit    sol;
      bit    sof;
      string req;
      string ctx;
   } exp_t;

   exp_t expq[$];
   int   rstore[$];
   int   n_chk = 0;
   int   n_fail = 0;
   int   cnt_model = 0;
   exp_t e;

   task automatic check(input bit cond, input string req, input string what,
                        input int act, input int expv);
      n_chk++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic int gen_r(input int k, input int x);
      case (k % 3)
         0:       return 5;
         1:       return (x * 3) % 11;
         default: return (x == 7) ? 255 : (x % 6);
      endcase
   endfunction

   function automatic int gen_l(input int k, input int x);
      if (k == 0) begin
         if (x < 5) return x + 1;
         case ((x - 5) % 6)
            0:       return 4;
            1:       return 5;
            2:       return 6;
            3:       return 3;
            4:       return 7;
            default: return 255;
         endcase
      end
      if (x == 3) return 255;
      return (x * 5 + k) % 9;
   endfunction

   task automatic drive_right(input int k);
      for (int x = 0; x < W; x++) begin
         if (x % 5 == 4) begin
            @(negedge clk);
            r_valid = 1'b0;
         end
         @(negedge clk);
         r_valid = 1'b1;
         r_sol   = (x == 0);
         r_data  = DW'(gen_r(k, x));
      end
      @(negedge clk);
      r_valid = 1'b0;
      r_sol   = 1'b0;
      for (int x = 0; x < W; x++) rstore.push_back(gen_r(k, x));
   endtask

   task automatic drive_left(input int k, input bit sof, input string ctx);
      for (int x = 0; x < W; x++) begin
         int   d, rd;
         exp_t t;
         if (x % 4 == 3) begin
            @(negedge clk);
            l_valid = 1'b0;
         end
         d = gen_l(k, x);
         @(negedge clk);
         l_valid = 1'b1;
         l_sol   = (x == 0);
         l_sof   = sof && (x == 0);
         l_data  = DW'(d);
         t.sol = (x == 0);
         t.sof = sof && (x == 0);
         t.ctx = ctx;
         if (d == INV) begin
            t.data = INV; t.req = "R6";
         end else if (x < d) begin
            t.data = INV; t.req = "R5";
         end else begin
            rd = rstore[x - d];
            if (rd == INV) begin
               t.data = INV; t.req = "R6";
            end else if (((d > rd) ? d - rd : rd - d) <= 1) begin
               t.data = d; t.req = "R3";
            end else begin
               t.data = INV; t.req = "R4";
            end
         end
         expq.push_back(t);
      end
      @(negedge clk);
      l_valid = 1'b0;
      l_sol   = 1'b0;
      l_sof   = 1'b0;
      for (int x = 0; x < W; x++) void'(rstore.pop_front());
   endtask

   // Compare against the model on every clock, after the edge has settled
   always @(posedge clk) begin
      #1;
      if (rst_n && o_valid) begin
         if (expq.size() == 0) begin
            check(1'b0, "R1", "output without left pixel", o_data, -1);
         end else begin
            e = expq.pop_front();
            check(int'(o_data) == e.data, e.req, {"data ", e.ctx}, o_data, e.data);
            check(o_sol == e.sol, "R2", "o_sol", o_sol, e.sol);
            check(o_sof == e.sof, "R2", "o_sof", o_sof, e.sof);
            cnt_model = (e.sof ? 0 : cnt_model) + ((e.data == INV) ? 1 : 0);
            check(int'(o_bad_cnt) == cnt_model, "R8", "o_bad_cnt", o_bad_cnt, cnt_model);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check(o_valid == 1'b0, "R9", "o_valid in reset", o_valid, 0);
      check(o_bad_cnt == '0, "R9", "o_bad_cnt in reset", o_bad_cnt, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(o_valid == 1'b0 && o_sol == 1'b0 && o_sof == 1'b0, "R9", "idle after reset", o_valid, 0);
      // Frame 1: tolerance edges, line start, flags
      drive_right(0);
      repeat (3) @(negedge clk);
      check(o_valid == 1'b0, "R1", "right stream alone gives no output", o_valid, 0);
      fork
         drive_right(1);
         drive_left(0, 1'b1, "line0");
      join
      fork
         drive_right(2);
         drive_left(1, 1'b0, "R7 overlap line1");
      join
      drive_left(2, 1'b0, "R7 overlap line2");
      // Frame 2: counter restarts on frame marker (R8)
      drive_right(3);
      drive_left(3, 1'b1, "frame2");
      repeat (4) @(negedge clk);
      check(expq.size() == 0, "R1", "outputs missing", expq.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule